// File: doc/BRIEF.md
# Tri-State Rising-Edge Phase-Frequency Comparator

This block compares a reference signal against a feedback signal, normally the output of an oscillator or a divider in a digital or mixed-signal loop, and produces correction requests for a charge pump or loop filter. It runs on a fast system clock and first passes both inputs through multi-stage synchronisers. A twelve-state machine then follows the logic levels of both inputs. Only rising edges move the machine between its three output modes: pumping up, pumping down, or holding with the charge output released (high impedance). Falling edges only update the recorded input levels.

A rising reference edge asks for "up" unless a "down" request is pending, in which case the two cancel and the output returns to hold. A rising feedback edge does the mirror operation. The result: at equal frequencies the active request lasts as long as the phase difference, and when one input runs faster its request stays on. A separate lock flag is high whenever the output is in hold, so it can serve as a raw in-phase indicator. When both synchronised inputs change in the same cycle, the machine handles the reference change first and the feedback change one cycle later. This keeps the single-change assumption of the state machine intact.

Top module: `tri_pfd`

## Requirements
- R1: A synchronous active-high reset puts the machine in its idle hold state with both inputs recorded low: `up_o`=0, `dn_o`=0, `drive_en_o`=0, `lock_o`=1.
- R2: From hold with both inputs low, a rising reference edge asserts `up_o`. It stays asserted until a rising feedback edge arrives, which returns the outputs to hold (`up_o`=0, `dn_o`=0, `lock_o`=1).
- R3: From hold with both inputs low, a rising feedback edge asserts `dn_o`. It stays asserted until a rising reference edge arrives, which returns the outputs to hold.
- R4: Falling edges on either input never change `up_o`, `dn_o`, `drive_en_o` or `lock_o`, so input duty cycle has no effect.
- R5: Two or more reference rises with no feedback rise between them keep `up_o` asserted throughout (reference faster than feedback).
- R6: Two or more feedback rises with no reference rise between them keep `dn_o` asserted throughout (feedback faster than reference).
- R7: `up_o` and `dn_o` are never both high, and `drive_en_o` equals `up_o` OR `dn_o`.
- R8: `lock_o` is high exactly when `drive_en_o` is low.
- R9: When both synchronised inputs change in the same cycle, the reference change takes effect first and the feedback change one clock later. For example, both rising together from idle gives one cycle of `up_o` followed by hold.
- R10: An input change takes effect at the outputs on the (SYNC_STAGES+1)-th rising clock edge after it is applied (the third edge with the default of 2). Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either compared signal |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference signal, asynchronous |
| fbk_i | input | 1 | Feedback signal from oscillator or divider, asynchronous |
| up_o | output | 1 | Request to raise the oscillator frequency |
| dn_o | output | 1 | Request to lower the oscillator frequency |
| drive_en_o | output | 1 | Charge output driven; low models high impedance |
| lock_o | output | 1 | High while the comparator is in a hold state |

## Verification
If the recorded input level inside a state is wrong, the next edge on that input is misread. A rise can be taken for a fall or missed entirely, so a pending request fails to cancel or a new one fails to start. That shows on `up_o`/`dn_o` at the very next opposite-input edge, within the latency of R10. A wrong mode bit shows at once as a request in a hold state or as a broken `lock_o` relation. The bench therefore walks both lead and lag sequences, frequency imbalance in both directions, falling edges in every mode and simultaneous changes, and checks every step against an independent level-and-mode model.

// File: rtl/tri_pfd_pkg.sv
package tri_pfd_pkg;

    // Twelve states; the name tells the output mode and the recorded
    // (reference, feedback) levels.
    typedef enum logic [3:0] {
        S_HZ_LL = 4'd1,
        S_DN_LH = 4'd2,
        S_UP_HL = 4'd3,
        S_DN_LL = 4'd4,
        S_UP_LL = 4'd5,
        S_HZ_HH = 4'd6,
        S_HZ_LH = 4'd7,
        S_HZ_HL = 4'd8,
        S_UP_HH = 4'd9,
        S_DN_HL = 4'd10,
        S_UP_LH = 4'd11,
        S_DN_HH = 4'd12
    } pfd_state_e;

    typedef enum logic [1:0] {
        M_HOLD = 2'd0,
        M_UP   = 2'd1,
        M_DOWN = 2'd2
    } pfd_mode_e;

    typedef struct packed {
        pfd_state_e state;
    } pfd_regs_t;

    function automatic pfd_mode_e mode_of(input pfd_state_e s);
        case (s)
            S_UP_HL, S_UP_LL, S_UP_HH, S_UP_LH: mode_of = M_UP;
            S_DN_LH, S_DN_LL, S_DN_HL, S_DN_HH: mode_of = M_DOWN;
            default:                            mode_of = M_HOLD;
        endcase
    endfunction

    function automatic logic ref_lvl_of(input pfd_state_e s);
        case (s)
            S_UP_HL, S_HZ_HH, S_HZ_HL, S_UP_HH, S_DN_HL, S_DN_HH: ref_lvl_of = 1'b1;
            default:                                              ref_lvl_of = 1'b0;
        endcase
    endfunction

    function automatic logic fbk_lvl_of(input pfd_state_e s);
        case (s)
            S_DN_LH, S_HZ_HH, S_HZ_LH, S_UP_HH, S_UP_LH, S_DN_HH: fbk_lvl_of = 1'b1;
            default:                                              fbk_lvl_of = 1'b0;
        endcase
    endfunction

    function automatic pfd_state_e compose(input pfd_mode_e m, input logic r, input logic f);
        pfd_state_e s;
        case ({m, r, f})
            {M_HOLD, 1'b0, 1'b0}: s = S_HZ_LL;
            {M_HOLD, 1'b0, 1'b1}: s = S_HZ_LH;
            {M_HOLD, 1'b1, 1'b0}: s = S_HZ_HL;
            {M_HOLD, 1'b1, 1'b1}: s = S_HZ_HH;
            {M_UP,   1'b0, 1'b0}: s = S_UP_LL;
            {M_UP,   1'b0, 1'b1}: s = S_UP_LH;
            {M_UP,   1'b1, 1'b0}: s = S_UP_HL;
            {M_UP,   1'b1, 1'b1}: s = S_UP_HH;
            {M_DOWN, 1'b0, 1'b0}: s = S_DN_LL;
            {M_DOWN, 1'b0, 1'b1}: s = S_DN_LH;
            {M_DOWN, 1'b1, 1'b0}: s = S_DN_HL;
            {M_DOWN, 1'b1, 1'b1}: s = S_DN_HH;
            default:              s = S_HZ_LL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tri_pfd_sync.sv
module tri_pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/tri_pfd_fsm.sv
module tri_pfd_fsm
    import tri_pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_s,
    input  logic       fbk_s,
    output pfd_state_e state_o
);
    pfd_regs_t regs_d, regs_q;

    always_comb begin
        pfd_mode_e m;
        logic      r;
        logic      f;
        m = mode_of(regs_q.state);
        r = ref_lvl_of(regs_q.state);
        f = fbk_lvl_of(regs_q.state);
        regs_d = regs_q;
        if (ref_s != r) begin
            // Reference change handled first; a feedback change waits a cycle.
            if (ref_s) m = (m == M_DOWN) ? M_HOLD : M_UP;
            r = ref_s;
        end else if (fbk_s != f) begin
            if (fbk_s) m = (m == M_UP) ? M_HOLD : M_DOWN;
            f = fbk_s;
        end
        regs_d.state = compose(m, r, f);
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.state <= S_HZ_LL;
        else     regs_q       <= regs_d;
    end

    assign state_o = regs_q.state;
endmodule

// File: rtl/tri_pfd_outdec.sv
module tri_pfd_outdec
    import tri_pfd_pkg::*;
(
    input  pfd_state_e state_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       drive_en_o,
    output logic       lock_o
);
    always_comb begin
        up_o = 1'b0;
        dn_o = 1'b0;
        case (state_i)
            S_UP_HL, S_UP_LL, S_UP_HH, S_UP_LH: up_o = 1'b1;
            S_DN_LH, S_DN_LL, S_DN_HL, S_DN_HH: dn_o = 1'b1;
            default: ;
        endcase
        drive_en_o = up_o | dn_o;
        case (state_i)
            S_HZ_LL, S_HZ_HH, S_HZ_LH, S_HZ_HL: lock_o = 1'b1;
            default:                            lock_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tri_pfd.sv
module tri_pfd
    import tri_pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic fbk_i,
    output logic up_o,
    output logic dn_o,
    output logic drive_en_o,
    output logic lock_o
);
    logic       ref_s;
    logic       fbk_s;
    pfd_state_e state;

    tri_pfd_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
        .clk(clk), .rst(rst), .async_i(ref_i), .sync_o(ref_s)
    );

    tri_pfd_sync #(.STAGES(SYNC_STAGES)) u_sync_fbk (
        .clk(clk), .rst(rst), .async_i(fbk_i), .sync_o(fbk_s)
    );

    tri_pfd_fsm u_fsm (
        .clk(clk), .rst(rst), .ref_s(ref_s), .fbk_s(fbk_s), .state_o(state)
    );

    tri_pfd_outdec u_dec (
        .state_i(state), .up_o(up_o), .dn_o(dn_o),
        .drive_en_o(drive_en_o), .lock_o(lock_o)
    );
endmodule

// File: rtl/tri_pfd_checks.sv
module tri_pfd_checks (
    input logic clk,
    input logic rst,
    input logic up,
    input logic dn,
    input logic oe,
    input logic lk,
    input logic ref_s,
    input logic fbk_s
);
    AST_NO_BOTH_REQ: assert property (@(posedge clk) disable iff (rst) !(up && dn)); // R7
    AST_OE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) oe == (up || dn)); // R7
    AST_LOCK_IN_HOLD: assert property (@(posedge clk) disable iff (rst) lk == !oe); // R8
    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!up && !dn && lk)); // R1
    AST_DN_NEEDS_FBK_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(dn) |-> $past(fbk_s)); // R3
    AST_UP_NEEDS_REF_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(up) |-> $past(ref_s)); // R2
    AST_UP_NO_DIRECT_DN: assert property (@(posedge clk) disable iff (rst) $past(up) |-> !dn); // R7
endmodule

bind tri_pfd tri_pfd_checks u_chk (
    .clk(clk), .rst(rst), .up(up_o), .dn(dn_o), .oe(drive_en_o),
    .lk(lock_o), .ref_s(ref_s), .fbk_s(fbk_s)
);

// File: tb/tri_pfd_test.sv
module tri_pfd_test;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    typedef struct {
        logic  up;
        logic  dn;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_i = 1'b0;
    logic fbk_i = 1'b0;
    logic up_o, dn_o, drive_en_o, lock_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Independent model: 0 hold, 1 up, 2 down; plus last seen levels.
    int   m_mode = 0;
    logic m_ref  = 1'b0;
    logic m_fbk  = 1'b0;

    exp_t sb_q[$];
    event chk_ev;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_pfd #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .ref_i(ref_i), .fbk_i(fbk_i),
        .up_o(up_o), .dn_o(dn_o), .drive_en_o(drive_en_o), .lock_o(lock_o)
    );

    task automatic compare(input logic eu, input logic ed, input string tag);
        logic eoe, elk;
        eoe = eu | ed;
        elk = ~eoe;
        n_checks++;
        if (up_o !== eu || dn_o !== ed || drive_en_o !== eoe || lock_o !== elk) begin
            n_fail++;
            $display("FAIL %s: up/dn/oe/lock got %b%b%b%b expected %b%b%b%b",
                     tag, up_o, dn_o, drive_en_o, lock_o, eu, ed, eoe, elk);
        end
    endtask

    // Monitor: pops expected items and compares with live outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.up, e.dn, e.tag);
            end
        end
    end

    function automatic void model_ref(input logic v);
        if (v && !m_ref) m_mode = (m_mode == 2) ? 0 : 1;
        m_ref = v;
    endfunction

    function automatic void model_fbk(input logic v);
        if (v && !m_fbk) m_mode = (m_mode == 1) ? 0 : 2;
        m_fbk = v;
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        e.up = (m_mode == 1);
        e.dn = (m_mode == 2);
        e.tag = tag;
        sb_q.push_back(e);
        ->chk_ev;
        #0;
    endtask

    // Driver: apply levels at a falling edge, wait out the latency, expect.
    task automatic apply(input logic r, input logic f, input string tag);
        @(negedge clk);
        ref_i = r;
        fbk_i = f;
        model_ref(r);
        model_fbk(f);
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
        push_exp(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        push_exp("R1 reset idle");
        rst = 1'b0;
        @(negedge clk);
        push_exp("R1 after release");

        // Reference leads: up until feedback rise.
        apply(1, 0, "R2 ref rise -> up");
        apply(1, 1, "R2 fbk rise -> hold");
        apply(0, 1, "R4 ref fall in hold");
        apply(0, 0, "R4 fbk fall in hold");

        // Feedback leads: down until reference rise.
        apply(0, 1, "R3 fbk rise -> down");
        apply(0, 0, "R4 fbk fall keeps down");
        apply(1, 0, "R3 ref rise -> hold");
        apply(0, 0, "R4 ref fall idle");

        // Reference faster: two ref rises before one fbk rise.
        apply(1, 0, "R5 first ref rise");
        apply(0, 0, "R4 ref fall keeps up");
        apply(1, 0, "R5 second ref rise still up");
        apply(0, 0, "R5 ref fall still up");
        apply(0, 1, "R5 fbk rise cancels up");
        apply(0, 0, "R5 idle");

        // Feedback faster.
        apply(0, 1, "R6 first fbk rise");
        apply(0, 0, "R6 fbk fall");
        apply(0, 1, "R6 second fbk rise still down");
        apply(1, 1, "R6 ref rise cancels down");
        apply(0, 0, "R6 both fall idle");

        // R10 latency: unchanged before edge SYNC+1, changed after it.
        @(negedge clk);
        ref_i = 1'b1;
        repeat (SYNC) @(posedge clk);
        #1;
        compare(1'b0, 1'b0, "R10 before latency edge");
        @(posedge clk);
        #1;
        compare(1'b1, 1'b0, "R10 at latency edge");
        model_ref(1'b1);
        apply(1, 1, "R10 back to hold");
        apply(0, 0, "R10 idle");

        // R9: simultaneous rise, reference first then feedback.
        @(negedge clk);
        ref_i = 1'b1;
        fbk_i = 1'b1;
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
        compare(1'b1, 1'b0, "R9 ref handled first");
        @(negedge clk);
        compare(1'b0, 1'b0, "R9 fbk handled next cycle");
        m_ref = 1'b1;
        m_fbk = 1'b1;
        m_mode = 0;
        apply(0, 0, "R9 idle");

        // R9 from down state: fbk-first pending down; both rise then.
        apply(0, 1, "R9 setup down");
        apply(0, 0, "R9 setup fbk low");
        @(negedge clk);
        ref_i = 1'b1;
        fbk_i = 1'b1;
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
        compare(1'b0, 1'b0, "R9 ref cancels down first");
        @(negedge clk);
        compare(1'b0, 1'b1, "R9 then fbk gives down");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        #1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule